// File: doc/BRIEF.md
# Ping-Pong Stream Integrity Checker

This block sits at the receiving end of two AXI4-Stream channels. A ping-pong switch upstream cuts one continuous counting stream into fixed-length packets and sends them to the two channels in turn. The checker accepts every beat on both channels, because its tready outputs are held high. For each beat it checks the byte enables and the counting sequence, whether the beat is on the channel whose turn it is, and where the beat falls in the packet. It also checks that the final word of the k-th packet equals k times the packet length.

A packet closes on an accepted tlast. It also closes on the beat that reaches the configured length, whether or not tlast is set on that beat. When a packet closes, exactly one of two 32-bit counters advances: the good counter when nothing went wrong in the packet, the bad counter otherwise. Each kind of fault also sets a flag of its own, and the flag stays set until reset. After a data mismatch, the expected value moves to the received word plus one. One slip therefore does not make every following beat fail.

Word width and packet length are parameters. The default length is 100000 words. A short length keeps simulation brief.

Top module: `pingpong_stream_checker`

## Requirements
- R1: After reset, both counters read 0, all four error flags and packet_done are 0, and ch0_tready and ch1_tready are 1 at all times.
- R2: The first accepted word after reset must be 1, and each later accepted word must be exactly one more than the word before it on either channel. A mismatch sets data_error and makes the current packet bad.
- R3: The first packet after reset is expected on channel 0, and the expected channel toggles each time a packet closes. A beat on the other channel sets wrong_channel and makes the packet bad.
- R4: A packet closes on an accepted tlast, or on its PKT_LEN-th beat if tlast is absent there. A tlast before beat PKT_LEN, or a missing tlast on beat PKT_LEN, sets length_error and makes the packet bad. The next beat starts a new packet.
- R5: The final word of the k-th packet closed since reset must equal k*PKT_LEN. A mismatch only makes the packet bad and sets no flag.
- R6: Every accepted beat must carry tkeep with all bits set (4'b1111 for 32-bit data). Any other value sets keep_error and makes the packet bad.
- R7: When a packet closes, exactly one counter advances by one: good_packets if the packet had no fault, bad_packets otherwise.
- R8: packet_done is high for exactly one cycle, the cycle after each accepted tlast. A packet closed at the length limit without tlast produces no pulse.
- R9: Idle cycles of any length between beats, inside a packet or between packets, and back-to-back beats with no idle cycles, raise no error.
- R10: Each error flag stays set until the next reset, even when later traffic is clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released synchronously inside the block |
| ch0_tvalid | input | 1 | Channel 0 beat valid |
| ch0_tready | output | 1 | Channel 0 ready, always 1 |
| ch0_tdata | input | DATA_W | Channel 0 data word |
| ch0_tkeep | input | DATA_W/8 | Channel 0 byte enables |
| ch0_tlast | input | 1 | Channel 0 end of packet |
| ch1_tvalid | input | 1 | Channel 1 beat valid |
| ch1_tready | output | 1 | Channel 1 ready, always 1 |
| ch1_tdata | input | DATA_W | Channel 1 data word |
| ch1_tkeep | input | DATA_W/8 | Channel 1 byte enables |
| ch1_tlast | input | 1 | Channel 1 end of packet |
| good_packets | output | CNT_W | Number of fault-free packets closed |
| bad_packets | output | CNT_W | Number of faulty packets closed |
| packet_done | output | 1 | One-cycle pulse after each accepted tlast |
| wrong_channel | output | 1 | Sticky: a beat arrived on the channel that was not expected |
| data_error | output | 1 | Sticky: the counting sequence broke |
| length_error | output | 1 | Sticky: tlast came early or was missing |
| keep_error | output | 1 | Sticky: a beat had tkeep not all ones |

## Verification
The assertions assume that the upstream switch never drives both channels valid in the same cycle, since a single source feeds both. A property in the top module checks this assumption. The bench drives one channel at a time and clears the other channel's valid before it changes channel.

The properties assume that the packet length is at least 2, so that the beat counter has at least one bit. The bench uses a length of 16.

The stimulus covers the following patterns:
- bursts of eight beats separated by six idle cycles, and long idle gaps between packets;
- gapless back-to-back packets;
- a packet sent on the wrong channel;
- a skipped word;
- an early tlast and a missing tlast;
- a beat with a partial tkeep.

In each faulty case the bench checks that only the intended flag is raised.

// File: rtl/psc_pkg.sv
package psc_pkg;
  typedef enum logic {
    CH_PING = 1'b0,
    CH_PONG = 1'b1
  } chan_e;
endpackage

// File: rtl/psc_beat_mux.sv
module psc_beat_mux
  import psc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                ch0_vld,
  input  logic [DATA_W-1:0]   ch0_data,
  input  logic [DATA_W/8-1:0] ch0_keep,
  input  logic                ch0_last,
  input  logic                ch1_vld,
  input  logic [DATA_W-1:0]   ch1_data,
  input  logic [DATA_W/8-1:0] ch1_keep,
  input  logic                ch1_last,
  output logic                beat_vld,
  output chan_e               beat_ch,
  output logic [DATA_W-1:0]   beat_data,
  output logic [DATA_W/8-1:0] beat_keep,
  output logic                beat_last
);
  // A single source feeds both channels, so at most one is valid in a cycle;
  // channel 0 wins if that assumption is broken.
  always_comb begin
    beat_vld = ch0_vld | ch1_vld;
    if (ch0_vld) begin
      beat_ch   = CH_PING;
      beat_data = ch0_data;
      beat_keep = ch0_keep;
      beat_last = ch0_last;
    end else begin
      beat_ch   = CH_PONG;
      beat_data = ch1_data;
      beat_keep = ch1_keep;
      beat_last = ch1_last;
    end
  end
endmodule

// File: rtl/psc_seq_track.sv
module psc_seq_track #(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                beat_vld,
  input  logic [DATA_W-1:0]   beat_data,
  input  logic [DATA_W/8-1:0] beat_keep,
  output logic                data_bad,
  output logic                keep_bad,
  output logic                data_error,
  output logic                keep_error
);
  localparam int KEEP_W = DATA_W / 8;

  logic [DATA_W-1:0] exp_q, exp_d;
  logic              derr_d, kerr_d;

  always_comb begin
    data_bad = beat_vld && (beat_data != exp_q);
    keep_bad = beat_vld && (beat_keep != {KEEP_W{1'b1}});
    derr_d   = data_error | data_bad;
    kerr_d   = keep_error | keep_bad;
    // Next expected word follows the received one, so a slip resynchronises.
    exp_d    = beat_data + DATA_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q      <= DATA_W'(1);
      data_error <= 1'b0;
      keep_error <= 1'b0;
    end else begin
      if (beat_vld) begin
        exp_q <= exp_d;
      end
      data_error <= derr_d;
      keep_error <= kerr_d;
    end
  end

  p_data_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    data_error |=> data_error);
  p_keep_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    keep_bad |=> keep_error);
endmodule

// File: rtl/psc_pkt_track.sv
module psc_pkt_track
  import psc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PKT_LEN = 100000,
  parameter int CNT_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_vld,
  input  chan_e             beat_ch,
  input  logic [DATA_W-1:0] beat_data,
  input  logic              beat_last,
  input  logic              beat_err,
  output logic [CNT_W-1:0]  good_cnt,
  output logic [CNT_W-1:0]  bad_cnt,
  output logic              packet_done,
  output logic              wrong_channel,
  output logic              length_error
);
  localparam int BC_W = $clog2(PKT_LEN);
  localparam logic [BC_W-1:0]   LAST_IDX = BC_W'(PKT_LEN - 1);
  localparam logic [DATA_W-1:0] STEP     = DATA_W'(PKT_LEN);

  logic [BC_W-1:0]   bcnt_q, bcnt_d;
  chan_e             exp_ch_q, exp_ch_d;
  logic [DATA_W-1:0] tgt_q, tgt_d;
  logic              pbad_q, pbad_d;
  logic [CNT_W-1:0]  good_d, bad_d;
  logic              done_d, wch_d, len_d;
  logic              at_len, ch_bad, len_bad, pkt_end, word_bad, beat_bad, pkt_fail;

  always_comb begin
    at_len   = (bcnt_q == LAST_IDX);
    ch_bad   = beat_vld && (beat_ch != exp_ch_q);
    len_bad  = beat_vld && (beat_last != at_len);
    pkt_end  = beat_vld && (beat_last || at_len);
    word_bad = pkt_end && (beat_data != tgt_q);
    beat_bad = beat_err | ch_bad | len_bad;
    pkt_fail = pbad_q | beat_bad | word_bad;

    bcnt_d   = bcnt_q;
    exp_ch_d = exp_ch_q;
    tgt_d    = tgt_q;
    pbad_d   = pbad_q;
    good_d   = good_cnt;
    bad_d    = bad_cnt;
    if (pkt_end) begin
      bcnt_d   = '0;
      exp_ch_d = (exp_ch_q == CH_PING) ? CH_PONG : CH_PING;
      tgt_d    = tgt_q + STEP;
      pbad_d   = 1'b0;
      if (pkt_fail) bad_d  = bad_cnt + CNT_W'(1);
      else          good_d = good_cnt + CNT_W'(1);
    end else if (beat_vld) begin
      bcnt_d = bcnt_q + BC_W'(1);
      pbad_d = pbad_q | beat_bad;
    end
    done_d = beat_vld && beat_last;
    wch_d  = wrong_channel | ch_bad;
    len_d  = length_error | len_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q        <= '0;
      exp_ch_q      <= CH_PING;
      tgt_q         <= STEP;
      pbad_q        <= 1'b0;
      good_cnt      <= '0;
      bad_cnt       <= '0;
      packet_done   <= 1'b0;
      wrong_channel <= 1'b0;
      length_error  <= 1'b0;
    end else begin
      if (beat_vld) begin
        bcnt_q   <= bcnt_d;
        exp_ch_q <= exp_ch_d;
        tgt_q    <= tgt_d;
        pbad_q   <= pbad_d;
        good_cnt <= good_d;
        bad_cnt  <= bad_d;
      end
      packet_done   <= done_d;
      wrong_channel <= wch_d;
      length_error  <= len_d;
    end
  end

  p_bcnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt_q <= LAST_IDX);
  p_good_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (good_cnt != $past(good_cnt)) |-> (good_cnt == $past(good_cnt) + CNT_W'(1)));
  p_one_counter_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (good_cnt != $past(good_cnt)) |-> (bad_cnt == $past(bad_cnt)));
  p_wrong_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wrong_channel |=> wrong_channel);
  p_len_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    length_error |=> length_error);
endmodule

// File: rtl/pingpong_stream_checker.sv
module pingpong_stream_checker
  import psc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PKT_LEN = 100000,
  parameter int CNT_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ch0_tvalid,
  output logic                ch0_tready,
  input  logic [DATA_W-1:0]   ch0_tdata,
  input  logic [DATA_W/8-1:0] ch0_tkeep,
  input  logic                ch0_tlast,
  input  logic                ch1_tvalid,
  output logic                ch1_tready,
  input  logic [DATA_W-1:0]   ch1_tdata,
  input  logic [DATA_W/8-1:0] ch1_tkeep,
  input  logic                ch1_tlast,
  output logic [CNT_W-1:0]    good_packets,
  output logic [CNT_W-1:0]    bad_packets,
  output logic                packet_done,
  output logic                wrong_channel,
  output logic                data_error,
  output logic                length_error,
  output logic                keep_error
);
  localparam int KEEP_W = DATA_W / 8;

  logic rst_meta, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign ch0_tready = 1'b1;
  assign ch1_tready = 1'b1;

  logic              beat_vld, beat_last, data_bad, keep_bad;
  chan_e             beat_ch;
  logic [DATA_W-1:0] beat_data;
  logic [KEEP_W-1:0] beat_keep;

  psc_beat_mux #(.DATA_W(DATA_W)) u_mux (
    .ch0_vld  (ch0_tvalid), .ch0_data(ch0_tdata), .ch0_keep(ch0_tkeep), .ch0_last(ch0_tlast),
    .ch1_vld  (ch1_tvalid), .ch1_data(ch1_tdata), .ch1_keep(ch1_tkeep), .ch1_last(ch1_tlast),
    .beat_vld (beat_vld),   .beat_ch (beat_ch),   .beat_data(beat_data),
    .beat_keep(beat_keep),  .beat_last(beat_last)
  );

  psc_seq_track #(.DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .beat_vld  (beat_vld),
    .beat_data (beat_data),
    .beat_keep (beat_keep),
    .data_bad  (data_bad),
    .keep_bad  (keep_bad),
    .data_error(data_error),
    .keep_error(keep_error)
  );

  psc_pkt_track #(.DATA_W(DATA_W), .PKT_LEN(PKT_LEN), .CNT_W(CNT_W)) u_pkt (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .beat_vld     (beat_vld),
    .beat_ch      (beat_ch),
    .beat_data    (beat_data),
    .beat_last    (beat_last),
    .beat_err     (data_bad | keep_bad),
    .good_cnt     (good_packets),
    .bad_cnt      (bad_packets),
    .packet_done  (packet_done),
    .wrong_channel(wrong_channel),
    .length_error (length_error)
  );

  p_one_source_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(ch0_tvalid && ch1_tvalid));
  p_done_from_last_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    packet_done |-> $past((ch0_tvalid && ch0_tlast) || (ch1_tvalid && ch1_tlast)));
endmodule

// File: tb/pingpong_stream_checker_tb.sv
module pingpong_stream_checker_tb;
  localparam int LEN = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ch0_tvalid, ch0_tlast, ch1_tvalid, ch1_tlast;
  logic        ch0_tready, ch1_tready;
  logic [31:0] ch0_tdata, ch1_tdata;
  logic [3:0]  ch0_tkeep, ch1_tkeep;
  logic [31:0] good_packets, bad_packets;
  logic        packet_done, wrong_channel, data_error, length_error, keep_error;

  int checks = 0;
  int failures = 0;
  int done_cnt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pingpong_stream_checker #(.DATA_W(32), .PKT_LEN(LEN), .CNT_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ch0_tvalid(ch0_tvalid), .ch0_tready(ch0_tready), .ch0_tdata(ch0_tdata),
    .ch0_tkeep(ch0_tkeep), .ch0_tlast(ch0_tlast),
    .ch1_tvalid(ch1_tvalid), .ch1_tready(ch1_tready), .ch1_tdata(ch1_tdata),
    .ch1_tkeep(ch1_tkeep), .ch1_tlast(ch1_tlast),
    .good_packets(good_packets), .bad_packets(bad_packets), .packet_done(packet_done),
    .wrong_channel(wrong_channel), .data_error(data_error),
    .length_error(length_error), .keep_error(keep_error)
  );

  always @(negedge clk) if (rst_n && packet_done) done_cnt++;

  task automatic check_eq(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ch0_tvalid = 1'b0; ch1_tvalid = 1'b0;
      ch0_tlast  = 1'b0; ch1_tlast  = 1'b0;
    end
  endtask

  task automatic beat(bit ch, int data, logic [3:0] keep, bit last);
    @(negedge clk);
    ch0_tvalid = (ch == 0); ch1_tvalid = (ch == 1);
    ch0_tdata = data; ch1_tdata = data;
    ch0_tkeep = keep; ch1_tkeep = keep;
    ch0_tlast = (ch == 0) && last; ch1_tlast = (ch == 1) && last;
  endtask

  // n beats from 'first'; tlast on beat 'last_at' (1-based, 0 = never); optional burst gaps
  task automatic packet(bit ch, int first, int n, int last_at, bit gaps);
    for (int i = 0; i < n; i++) begin
      beat(ch, first + i, 4'hF, (i + 1) == last_at);
      if (gaps && (i % 8 == 7) && (i != n - 1)) idle(6);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ch0_tvalid = 0; ch1_tvalid = 0; ch0_tlast = 0; ch1_tlast = 0;
    ch0_tdata = 0; ch1_tdata = 0; ch0_tkeep = 0; ch1_tkeep = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    done_cnt = 0;
  endtask

  task automatic expect_state(string req, int good, int bad, bit wch, bit derr, bit lerr, bit kerr, int dones);
    check_eq({req, " good_packets"}, good_packets, good);
    check_eq({req, " bad_packets"}, bad_packets, bad);
    check_eq({req, " wrong_channel"}, wrong_channel, wch);
    check_eq({req, " data_error"}, data_error, derr);
    check_eq({req, " length_error"}, length_error, lerr);
    check_eq({req, " keep_error"}, keep_error, kerr);
    check_eq({req, " packet_done pulses"}, done_cnt, dones);
  endtask

  task automatic t_reset();
    do_reset();
    expect_state("R1 reset", 0, 0, 0, 0, 0, 0, 0);
    check_eq("R1 packet_done", packet_done, 0);
    check_eq("R1 tready", {ch0_tready, ch1_tready}, 2'b11);
  endtask

  task automatic t_alternating_gaps();
    do_reset();
    packet(0, 1, LEN, LEN, 1);
    idle(40);
    packet(1, LEN + 1, LEN, LEN, 1);
    idle(3);
    packet(0, 2 * LEN + 1, LEN, LEN, 1);
    idle(2);
    expect_state("R9 R7 R5 alternating with gaps", 3, 0, 0, 0, 0, 0, 3);
    check_eq("R8 packet_done low after pulse", packet_done, 0);
  endtask

  task automatic t_back_to_back();
    do_reset();
    packet(0, 1, LEN, LEN, 0);
    packet(1, LEN + 1, LEN, LEN, 0);
    idle(2);
    expect_state("R9 gapless", 2, 0, 0, 0, 0, 0, 2);
  endtask

  task automatic t_wrong_channel();
    do_reset();
    packet(1, 1, LEN, LEN, 0);
    idle(2);
    expect_state("R3 wrong channel", 0, 1, 1, 0, 0, 0, 1);
    packet(0, LEN + 1, LEN, LEN, 0);   // channel 0 now wrong again (ch1 expected)
    idle(2);
    expect_state("R10 R3 sticky", 0, 2, 1, 0, 0, 0, 2);
  endtask

  task automatic t_data_skip();
    do_reset();
    for (int i = 1; i <= LEN; i++) beat(0, (i <= 5) ? i : i + 1, 4'hF, i == LEN);
    idle(2);
    expect_state("R2 skipped word", 0, 1, 0, 1, 0, 0, 1);
  endtask

  task automatic t_early_last();
    do_reset();
    packet(0, 1, 10, 10, 0);
    idle(2);
    expect_state("R4 early tlast", 0, 1, 0, 0, 1, 0, 1);
    packet(1, 11, LEN, LEN, 0);   // continuous data, right channel, last 26 != 32
    idle(2);
    expect_state("R5 last word mismatch", 0, 2, 0, 0, 1, 0, 2);
  endtask

  task automatic t_missing_last();
    do_reset();
    packet(0, 1, LEN, 0, 0);
    idle(2);
    expect_state("R4 R8 missing tlast", 0, 1, 0, 0, 1, 0, 0);
    packet(1, LEN + 1, LEN, LEN, 0);
    idle(2);
    expect_state("R4 new packet after limit", 1, 1, 0, 0, 1, 0, 1);
  endtask

  task automatic t_keep();
    do_reset();
    for (int i = 1; i <= LEN; i++) beat(0, i, (i == 3) ? 4'h7 : 4'hF, i == LEN);
    idle(2);
    expect_state("R6 partial tkeep", 0, 1, 0, 0, 0, 1, 1);
    packet(1, LEN + 1, LEN, LEN, 0);
    idle(2);
    expect_state("R10 R6 sticky keep", 1, 1, 0, 0, 0, 1, 2);
  endtask

  initial begin
    t_reset();
    t_alternating_gaps();
    t_back_to_back();
    t_wrong_channel();
    t_data_skip();
    t_early_last();
    t_missing_last();
    t_keep();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule